// File: doc/BRIEF.md
# T1 Line Alarm and Error Detector

This block watches the two receive rails of a bipolar T1 line, one bit time per clock, together with the framer's per-frame comparison strobes. It raises live condition levels for carrier loss and the all-ones (blue) alarm, and one-cycle pulses for bipolar violations, B8ZS code words and framing bit errors. These are the raw inputs to a receive status register.

Three event counters sit beside the detectors. An 8-bit counter tallies bipolar violations. Two 4-bit counters tally framing bit errors and CRC errors. Every counter stops at all ones instead of wrapping. A host write port can preload any counter, and two flags report saturation. When B8ZS is enabled, the two deliberate violations inside each substitution code word are held back from the violation count. To allow this, each violation is reported four bit times after the bit that carried it.

Top module: `t1_alarm_monitor`

## Requirements
- R1: After reset every output is 0: all flags, all pulses and all three counters.
- R2: `carrier_loss` rises at the clock edge that samples the 32nd consecutive bit with both rails low. It falls at the edge that samples a bit with either rail high.
- R3: A frame is the set of bits sampled after one `fbit` bit and before the next. Bits seen before the first `fbit` form no frame, and `fbit` bits are never counted. At each `fbit` edge after the first, the frame just ended is judged "low" if it held fewer than 3 zero bits. `blue_alarm` is set to 1 exactly when this frame and the frame judged at the previous `fbit` edge were both low. `blue_alarm` changes only at `fbit` edges.
- R4: A mark is a bit with either rail high. When both rails are high the mark counts as positive. A violation is a mark of the same polarity as the previous mark. `bpv` pulses for one cycle after the edge that comes four clock edges after the edge sampling the violating bit. `viol_cnt` increments on that same edge.
- R5: With `b8zs_en` high, eight bits forming 0,0,0,V,B,0,V,B make `b8zs_det` pulse after the edge that samples the eighth bit. In this pattern V is a mark equal in polarity to the previous mark and B is a mark of the opposite polarity. The violations at positions 4 and 7 then produce no `bpv` pulse and no count. With `b8zs_en` low there is no detection, and those violations count as normal.
- R6: `frame_err` pulses after the edge that samples `fps_err` high when `esf_mode` is 1, or `ft_err` high when `esf_mode` is 0. The other strobe is ignored. Each pulse increments `err_a_cnt`.
- R7: Each edge that samples `crc_err` high increments `err_b_cnt`.
- R8: Counters hold at all ones. `viol_sat` is 1 exactly when `viol_cnt` is all ones. `err_sat` is 1 exactly when either error counter is all ones.
- R9: When `wr_en` is high at an edge, `wr_sel` = 0 loads `viol_cnt` from `wr_data`. `wr_sel` = 1 loads `err_a_cnt` from `wr_data[3:0]`, and `wr_sel` = 2 loads `err_b_cnt` from `wr_data[3:0]`. The load takes priority over an increment at the same edge. `wr_sel` = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pos | input | 1 | Positive rail, high for a positive mark |
| rx_neg | input | 1 | Negative rail, high for a negative mark |
| fbit | input | 1 | Current bit is a framing bit position |
| b8zs_en | input | 1 | Enables code-word detection and violation retraction |
| esf_mode | input | 1 | 1 selects `fps_err`, 0 selects `ft_err` |
| ft_err | input | 1 | Terminal framing bit mismatch strobe |
| fps_err | input | 1 | Framing pattern sequence mismatch strobe |
| crc_err | input | 1 | CRC mismatch strobe |
| wr_en | input | 1 | Host counter write strobe |
| wr_sel | input | 2 | Counter select for a write |
| wr_data | input | 8 | Value to load |
| carrier_loss | output | 1 | Carrier loss level |
| blue_alarm | output | 1 | All-ones alarm level |
| b8zs_det | output | 1 | Code word seen pulse |
| bpv | output | 1 | Counted bipolar violation pulse |
| frame_err | output | 1 | Framing bit error pulse |
| viol_cnt | output | 8 | Violation counter |
| err_a_cnt | output | 4 | Framing bit error counter |
| err_b_cnt | output | 4 | CRC error counter |
| viol_sat | output | 1 | Violation counter saturated |
| err_sat | output | 1 | An error counter saturated |

## Verification
Two pairs of functions can act on the same cycle. The first pair is a host load and a counter increment. The bench provokes it by writing `viol_cnt` in the middle of a run of same-polarity marks, and by writing the error counters while error strobes arrive. The expected result is that the loaded value appears with no added count. The second pair is code-word detection and the delayed emission of the code word's own fourth-bit violation. The reference model retracts that violation only when the eighth bit completes the word, so `b8zs_det` must rise while `bpv` stays low on the same cycle. With B8ZS disabled, the same violation must be counted.

// File: rtl/t1_alarm_monitor.sv
module t1_alarm_monitor #(
  parameter int CL_ZEROS   = 32,
  parameter int BLUE_ZEROS = 3,
  parameter int VC_W       = 8,
  parameter int EC_W       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_pos,
  input  logic            rx_neg,
  input  logic            fbit,
  input  logic            b8zs_en,
  input  logic            esf_mode,
  input  logic            ft_err,
  input  logic            fps_err,
  input  logic            crc_err,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [VC_W-1:0] wr_data,
  output logic            carrier_loss,
  output logic            blue_alarm,
  output logic            b8zs_det,
  output logic            bpv,
  output logic            frame_err,
  output logic [VC_W-1:0] viol_cnt,
  output logic [EC_W-1:0] err_a_cnt,
  output logic [EC_W-1:0] err_b_cnt,
  output logic            viol_sat,
  output logic            err_sat
);
  localparam int ZW = $clog2(CL_ZEROS + 1);
  localparam int BW = $clog2(BLUE_ZEROS + 1);

  logic          mark, viol_now, code_word, ferr_now, emit;
  logic          have_mark, last_pol;
  logic [6:0]    hist;
  logic [3:0]    vflag;
  logic [ZW-1:0] zrun, zrun_nx;
  logic [BW-1:0] zc;
  logic          seen_f, prev_low, frame_low;

  assign mark     = rx_pos | rx_neg;
  assign viol_now = mark & have_mark & (rx_pos == last_pol);

  // hist[k] / vflag[k]: mark and violation of the bit sampled k+1 edges ago
  assign code_word = b8zs_en & (hist[6:4] == 3'b000)
                   & hist[3] & vflag[3]
                   & hist[2] & ~vflag[2]
                   & ~hist[1]
                   & hist[0] & vflag[0]
                   & mark & ~viol_now;

  assign emit = vflag[3] & ~code_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist      <= '0;
      vflag     <= '0;
      have_mark <= 1'b0;
      last_pol  <= 1'b0;
      bpv       <= 1'b0;
      b8zs_det  <= 1'b0;
    end else begin
      hist     <= {hist[5:0], mark};
      vflag    <= {vflag[2], vflag[1], vflag[0] & ~code_word, viol_now};
      bpv      <= emit;
      b8zs_det <= code_word;
      if (mark) begin
        have_mark <= 1'b1;
        last_pol  <= rx_pos;
      end
    end
  end

  assign zrun_nx = mark ? '0 :
                   (zrun == ZW'(CL_ZEROS)) ? zrun : zrun + ZW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zrun         <= '0;
      carrier_loss <= 1'b0;
    end else begin
      zrun         <= zrun_nx;
      carrier_loss <= (zrun_nx == ZW'(CL_ZEROS));
    end
  end

  assign frame_low = (zc < BW'(BLUE_ZEROS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zc         <= '0;
      seen_f     <= 1'b0;
      prev_low   <= 1'b0;
      blue_alarm <= 1'b0;
    end else if (fbit) begin
      zc     <= '0;
      seen_f <= 1'b1;
      if (seen_f) begin
        prev_low   <= frame_low;
        blue_alarm <= frame_low & prev_low;
      end
    end else if (!mark && zc != BW'(BLUE_ZEROS)) begin
      zc <= zc + BW'(1);
    end
  end

  assign ferr_now = esf_mode ? fps_err : ft_err;

  always_ff @(posedge clk) begin
    if (!rst_n) frame_err <= 1'b0;
    else        frame_err <= ferr_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          viol_cnt <= '0;
    else if (wr_en && wr_sel == 2'd0)    viol_cnt <= wr_data;
    else if (emit && !(&viol_cnt))       viol_cnt <= viol_cnt + VC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          err_a_cnt <= '0;
    else if (wr_en && wr_sel == 2'd1)    err_a_cnt <= wr_data[EC_W-1:0];
    else if (ferr_now && !(&err_a_cnt))  err_a_cnt <= err_a_cnt + EC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          err_b_cnt <= '0;
    else if (wr_en && wr_sel == 2'd2)    err_b_cnt <= wr_data[EC_W-1:0];
    else if (crc_err && !(&err_b_cnt))   err_b_cnt <= err_b_cnt + EC_W'(1);
  end

  assign viol_sat = &viol_cnt;
  assign err_sat  = (&err_a_cnt) | (&err_b_cnt);
endmodule

// File: rtl/t1_alarm_monitor_chk.sv
module t1_alarm_monitor_chk #(
  parameter int VC_W = 8,
  parameter int EC_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rx_pos,
  input logic            rx_neg,
  input logic            fbit,
  input logic            ft_err,
  input logic            fps_err,
  input logic            wr_en,
  input logic [1:0]      wr_sel,
  input logic [VC_W-1:0] wr_data,
  input logic            carrier_loss,
  input logic            blue_alarm,
  input logic            b8zs_det,
  input logic            bpv,
  input logic            frame_err,
  input logic [VC_W-1:0] viol_cnt,
  input logic [EC_W-1:0] err_a_cnt,
  input logic            viol_sat
);
  // R2
  cl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pos || rx_neg) |=> !carrier_loss);

  // R3
  blue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fbit |=> $stable(blue_alarm));

  // R4
  viol_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 2'd0) |=>
      (viol_cnt == $past(viol_cnt) || viol_cnt == $past(viol_cnt) + VC_W'(1)));

  // R5
  cw_retract_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b8zs_det |-> !bpv);

  // R6
  ferr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ft_err && !fps_err) |=> !frame_err);

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_sat && !(wr_en && wr_sel == 2'd0)) |=> viol_sat);

  // R9
  load_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> err_a_cnt == $past(wr_data[EC_W-1:0]));
endmodule

bind t1_alarm_monitor t1_alarm_monitor_chk #(.VC_W(VC_W), .EC_W(EC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_pos(rx_pos), .rx_neg(rx_neg), .fbit(fbit),
  .ft_err(ft_err), .fps_err(fps_err), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .carrier_loss(carrier_loss), .blue_alarm(blue_alarm),
  .b8zs_det(b8zs_det), .bpv(bpv), .frame_err(frame_err),
  .viol_cnt(viol_cnt), .err_a_cnt(err_a_cnt), .viol_sat(viol_sat)
);

// File: tb/test_t1_alarm_monitor.sv
module test_t1_alarm_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_pos = 0, rx_neg = 0, fbit = 0, b8zs_en = 0, esf_mode = 0;
  logic ft_err = 0, fps_err = 0, crc_err = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic carrier_loss, blue_alarm, b8zs_det, bpv, frame_err, viol_sat, err_sat;
  logic [7:0] viol_cnt;
  logic [3:0] err_a_cnt, err_b_cnt;

  always #4 clk = ~clk;

  t1_alarm_monitor i_t1_alarm_monitor (
    .clk(clk), .rst_n(rst_n), .rx_pos(rx_pos), .rx_neg(rx_neg), .fbit(fbit),
    .b8zs_en(b8zs_en), .esf_mode(esf_mode), .ft_err(ft_err), .fps_err(fps_err),
    .crc_err(crc_err), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .carrier_loss(carrier_loss), .blue_alarm(blue_alarm), .b8zs_det(b8zs_det),
    .bpv(bpv), .frame_err(frame_err), .viol_cnt(viol_cnt), .err_a_cnt(err_a_cnt),
    .err_b_cnt(err_b_cnt), .viol_sat(viol_sat), .err_sat(err_sat));

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  int sym[$];
  int vq[$];
  int zrun = 0, lastmark = 0, zc = 0, va = 0, ea = 0, eb = 0;
  bit seen_f = 0, prev_low = 0;
  bit e_cl = 0, e_blue = 0, e_b8 = 0, e_bpv = 0, e_fe = 0;
  string wtag_v = "R4", wtag_a = "R6", wtag_b = "R7";

  // stimulus globals
  bit frame_on = 0;
  int fpos = 0;
  int lastp = -1;
  bit g_ft = 0, g_fps = 0, g_crc = 0, g_we = 0;
  logic [1:0] g_ws = 0;
  logic [7:0] g_wd = 0;

  task automatic chk(string tag, string name, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d at %0t", tag, name, got, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2", "carrier_loss", carrier_loss, e_cl);
    chk("R3", "blue_alarm", blue_alarm, e_blue);
    chk("R5", "b8zs_det", b8zs_det, e_b8);
    chk("R4", "bpv", bpv, e_bpv);
    chk("R6", "frame_err", frame_err, e_fe);
    chk(wtag_v, "viol_cnt", viol_cnt, va);
    chk(wtag_a, "err_a_cnt", err_a_cnt, ea);
    chk(wtag_b, "err_b_cnt", err_b_cnt, eb);
    chk("R8", "viol_sat", viol_sat, va == 255);
    chk("R8", "err_sat", err_sat, (ea == 15) || (eb == 15));
  endtask

  // s: 0 zero, 1 positive, -1 negative, 2 both rails (positive)
  task automatic step(int s);
    int sv, k;
    bit v, cw, fb, fe;
    fb = frame_on && fpos == 0;
    if (frame_on) fpos = (fpos + 1) % 193;
    sv = (s == 2) ? 1 : s;
    zrun = (sv == 0) ? ((zrun < 32) ? zrun + 1 : 32) : 0;
    e_cl = (zrun >= 32);
    v = (sv != 0) && (sv == lastmark);
    if (sv != 0) lastmark = sv;
    sym.push_back(sv);
    vq.push_back(int'(v));
    k = sym.size() - 1;
    cw = 0;
    if (b8zs_en && k >= 7)
      cw = sym[k-7] == 0 && sym[k-6] == 0 && sym[k-5] == 0 &&
           sym[k-4] != 0 && vq[k-4] == 1 && sym[k-3] == -sym[k-4] &&
           sym[k-2] == 0 && sym[k-1] == sym[k-3] && sym[k] == -sym[k-1];
    if (cw) begin
      vq[k-4] = 0;
      vq[k-1] = 0;
    end
    e_b8 = cw;
    e_bpv = (k >= 4) ? (vq[k-4] != 0) : 0;
    if (fb) begin
      if (seen_f) begin
        e_blue = (zc < 3) && prev_low;
        prev_low = (zc < 3);
      end
      seen_f = 1;
      zc = 0;
    end else if (sv == 0 && zc < 3) zc++;
    fe = esf_mode ? g_fps : g_ft;
    e_fe = fe;
    wtag_v = "R4"; wtag_a = "R6"; wtag_b = "R7";
    if (g_we && g_ws == 2'd0) begin va = g_wd; wtag_v = "R9"; end
    else if (e_bpv && va < 255) va++;
    if (g_we && g_ws == 2'd1) begin ea = g_wd[3:0]; wtag_a = "R9"; end
    else if (fe && ea < 15) ea++;
    if (g_we && g_ws == 2'd2) begin eb = g_wd[3:0]; wtag_b = "R9"; end
    else if (g_crc && eb < 15) eb++;
    if (g_we && g_ws == 2'd3) begin wtag_v = "R9"; wtag_a = "R9"; wtag_b = "R9"; end
    rx_pos = (s == 1 || s == 2);
    rx_neg = (s == -1 || s == 2);
    fbit = fb;
    ft_err = g_ft; fps_err = g_fps; crc_err = g_crc;
    wr_en = g_we; wr_sel = g_ws; wr_data = g_wd;
    g_ft = 0; g_fps = 0; g_crc = 0; g_we = 0;
    @(negedge clk);
    compare();
  endtask

  task automatic ami(int n, int zpct);
    for (int i = 0; i < n; i++) begin
      if (int'($urandom_range(99)) < zpct) step(0);
      else begin lastp = -lastp; step(lastp); end
    end
  endtask

  task automatic codeword();
    step(0); step(0); step(0);
    step(lastp); step(-lastp); step(0); step(-lastp); step(lastp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", "reset outputs", {carrier_loss, blue_alarm, b8zs_det, bpv, frame_err,
        viol_sat, err_sat}, 0);
    chk("R1", "reset counters", {viol_cnt, err_a_cnt, err_b_cnt}, 0);

    // R2 idle line then recovery, twice
    for (int i = 0; i < 40; i++) step(0);
    step(-1);
    for (int i = 0; i < 31; i++) step(0);
    step(1);
    for (int i = 0; i < 35; i++) step(0);
    lastp = 1;
    ami(60, 30);

    // R4 random symbols with violations, B8ZS off
    for (int i = 0; i < 300; i++) step(int'($urandom_range(2)) - 1);
    step(2); step(2); step(-1); step(2);

    // R5 code words enabled, then disabled
    b8zs_en = 1;
    lastp = -1;
    ami(20, 0);
    codeword();
    ami(9, 0);
    codeword(); codeword();
    ami(10, 20);
    for (int i = 0; i < 400; i++) step(int'($urandom_range(2)) - 1);
    b8zs_en = 0;
    ami(5, 0);
    codeword();
    ami(10, 0);

    // R3 blue alarm frames
    frame_on = 1; fpos = 0;
    ami(193 * 3, 0);
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < 193; i++) begin
        if (i == 50 || i == 120) step(0);
        else if (fpos == 0) step(0);
        else begin lastp = -lastp; step(lastp); end
      end
    end
    for (int i = 0; i < 193; i++) begin
      if (i == 10 || i == 70 || i == 150) step(0);
      else begin lastp = -lastp; step(lastp); end
    end
    ami(193 * 2, 0);
    ami(193, 1);
    frame_on = 0;

    // R8 and R9: violation counter saturation with writes
    b8zs_en = 1;
    for (int i = 0; i < 120; i++) step(1);
    g_we = 1; g_ws = 2'd0; g_wd = 8'd3;
    step(1);
    for (int i = 0; i < 300; i++) step(1);
    g_we = 1; g_ws = 2'd3; g_wd = 8'd5;
    step(1);
    g_we = 1; g_ws = 2'd0; g_wd = 8'd250;
    step(1);
    for (int i = 0; i < 12; i++) step(-1);
    g_we = 1; g_ws = 2'd0; g_wd = 8'hFF;
    step(0);
    ami(8, 0);

    // R6 R7 error strobes, mode changes, writes
    for (int i = 0; i < 200; i++) begin
      esf_mode = (i / 25) % 2 == 1;
      g_ft = ($urandom_range(3) == 0);
      g_fps = ($urandom_range(3) == 0);
      g_crc = ($urandom_range(2) == 0);
      if ($urandom_range(9) == 0) begin
        g_we = 1; g_ws = 2'($urandom_range(3)); g_wd = 8'($urandom_range(255));
      end
      lastp = -lastp;
      step(lastp);
    end
    g_ft = 1; g_fps = 1; g_crc = 1; g_we = 1; g_ws = 2'd1; g_wd = 8'h07;
    step(0);
    g_crc = 1; g_we = 1; g_ws = 2'd2; g_wd = 8'h0E;
    step(0);
    ami(5, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule